// File: doc/BRIEF.md
# Receive FIFO with Trigger Timeout

This block is the receive side of a buffered serial controller. A deserializer hands it bytes through a one-cycle valid strobe. The bytes go into a circular FIFO, 16 entries by default, that tracks its own fill level. Software drains the FIFO through a pop strobe. The oldest byte is always shown on the read-data port, and a separate port shows the number of bytes held.

A data-ready flag tells software that a batch is waiting. It rises when the fill level reaches a threshold chosen by a two-bit code. The flag also rises when the line has been quiet for a programmed number of character times while a smaller batch sits below the threshold. An interrupt follows the flag when receive interrupts are enabled.

The design has three parts:

- `rxq_ring` holds the storage and the pointers.
- `rxq_timeout` is the idle timer, with states TMR_IDLE and TMR_RUN. Its transitions are: start (TMR_IDLE to TMR_RUN), restart (TMR_RUN to TMR_RUN with a reload), expire (TMR_RUN to TMR_IDLE with a one-cycle fire) and cancel (any state to TMR_IDLE).
- `rxq_flags` sets the flag and the interrupt, with states FL_BELOW, FL_READY and FL_SIGNAL. Its transitions are:
  - raise: to FL_SIGNAL when interrupts are enabled, otherwise to FL_READY.
  - drain: to FL_BELOW when a pop takes the level under the threshold.
  - mute: FL_SIGNAL to FL_READY when interrupts are disabled.
  - flush: to FL_BELOW on a FIFO clear.

Top module: `rxq_trigger_top`

## Requirements
- R1: After reset the FIFO is empty, `fill_count` is 0, and `data_ready` and `rx_irq` are low.
- R2: `trig_sel` picks the threshold: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14.
- R3: If a stored byte brings the fill level to or above the threshold, `data_ready` goes high at that clock edge. `rx_irq` also goes high when `irq_enable` is set.
- R4: Bytes leave in arrival order. While the FIFO is not empty, `rd_data` shows the oldest byte. A `rd_pop` removes that byte and lowers `fill_count` by one.
- R5: If a pop leaves the fill level below the threshold, and no byte is stored in the same cycle, `data_ready` and `rx_irq` go low.
- R6: If a stored byte leaves the fill level below the threshold, the idle timer (re)starts. The timer runs TIMEOUT_CHARS*CHAR_CYCLES clock cycles. If no further byte arrives in that time, `data_ready` rises exactly that many cycles after the last byte's edge. `rx_irq` also rises if enabled.
- R7: `rx_irq` is never raised while `irq_enable` is low. It drops one cycle after `irq_enable` goes low, and `data_ready` is left unchanged.
- R8: While `rx_enable` is low, strobed bytes are not stored.
- R9: When the FIFO is empty, `rd_data` reads 8'hFF and a pop changes nothing.
- R10: A byte that arrives while the FIFO already holds DEPTH bytes is discarded.
- R11: `fifo_clear` takes priority over everything else. It empties the FIFO, drops `data_ready` and `rx_irq`, and stops the idle timer.
- R12: When the threshold is reached with `irq_enable` set, the pending idle timer is cancelled, so it cannot fire later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a byte is offered |
| rx_data | input | 8 | Offered byte |
| rx_enable | input | 1 | Receiver enable |
| irq_enable | input | 1 | Receive interrupt enable |
| trig_sel | input | 2 | Threshold code |
| fifo_clear | input | 1 | Empty the FIFO |
| rd_pop | input | 1 | Remove the oldest byte |
| rd_data | output | 8 | Oldest byte, or 8'hFF when empty |
| fill_count | output | 5 | Bytes held |
| data_ready | output | 1 | Threshold or timeout flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The bench builds the block with CHAR_CYCLES set to 4, so one timeout window is 60 cycles. At that length the bench can check the exact expiry cycle. It can also check a restart partway through a window, and check that the timer stays silent after a cancel. The default depth of 16 is kept, so the 14-entry threshold, the full-FIFO drop and pointer wraparound are all reached with a few dozen bytes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic {
        TMR_IDLE,
        TMR_RUN
    } tmr_state_e;

    typedef enum logic [1:0] {
        FL_BELOW,
        FL_READY,
        FL_SIGNAL
    } flag_state_e;

    function automatic int unsigned trig_level(input logic [1:0] code);
        int unsigned lvl;
        unique case (code)
            2'b00: lvl = 1;
            2'b01: lvl = 4;
            2'b10: lvl = 8;
            2'b11: lvl = 14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         push_req,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop_req,
    output logic [W-1:0]                 head_byte,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic [$clog2(DEPTH+1)-1:0]   count_next,
    output logic                         push_ok,
    output logic                         pop_ok
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign push_ok = push_req && !clear && (count < CW'(DEPTH));
    assign pop_ok  = pop_req  && !clear && (count != '0);

    always_comb begin
        if (clear) begin
            count_next = '0;
        end else begin
            count_next = count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    assign head_byte = (count == '0) ? '1 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_next;
            if (clear) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
                if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
        end
    end

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && !pop_req && !clear) |=> count == CW'(DEPTH));

    p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !clear && count != '0) |=> count == $past(count) - 1'b1);

    p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop_req && !push_req) |=> count == '0);

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count == '0);

endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout
    import rxq_pkg::*;
#(
    parameter int TICKS = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic cancel,
    output logic fire
);
    localparam int TW = $clog2(TICKS+1);

    tmr_state_e    state, state_nx;
    logic [TW-1:0] remain, remain_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= TMR_IDLE;
            remain <= '0;
        end else begin
            state  <= state_nx;
            remain <= remain_nx;
        end
    end

    always_comb begin
        state_nx  = state;
        remain_nx = remain;
        if (cancel) begin
            state_nx = TMR_IDLE;
        end else if (restart) begin
            state_nx  = TMR_RUN;
            remain_nx = TW'(TICKS-1);
        end else begin
            unique case (state)
                TMR_IDLE: ;
                TMR_RUN: begin
                    if (remain == '0) state_nx = TMR_IDLE;
                    else              remain_nx = remain - 1'b1;
                end
            endcase
        end
    end

    assign fire = (state == TMR_RUN) && (remain == '0) && !cancel && !restart;

    // checker: cycles elapsed since the last (re)start
    logic [TW-1:0] elapsed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          elapsed <= '0;
        else if (restart)                    elapsed <= '0;
        else if (elapsed != TW'(TICKS))      elapsed <= elapsed + 1'b1;
    end

    p_timeout_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> elapsed == TW'(TICKS-1));

    p_cancel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !fire);

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic set_evt,
    input  logic drop_evt,
    input  logic irq_enable,
    output logic data_ready,
    output logic rx_irq
);
    flag_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FL_BELOW;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (clear) begin
            state_nx = FL_BELOW;
        end else if (set_evt) begin
            state_nx = irq_enable ? FL_SIGNAL : FL_READY;
        end else if (drop_evt) begin
            state_nx = FL_BELOW;
        end else begin
            unique case (state)
                FL_BELOW:  ;
                FL_READY:  ;
                FL_SIGNAL: if (!irq_enable) state_nx = FL_READY;
                default:   state_nx = FL_BELOW;
            endcase
        end
    end

    always_comb begin
        data_ready = (state == FL_READY) || (state == FL_SIGNAL);
        rx_irq     = (state == FL_SIGNAL);
    end

    p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_enable |=> !rx_irq);

    p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_evt && !set_evt) |=> !data_ready);

    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !data_ready && !rx_irq);

    p_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && !clear) |=> data_ready);

endmodule

// File: rtl/rxq_trigger_top.sv
module rxq_trigger_top
    import rxq_pkg::*;
#(
    parameter int W             = 8,
    parameter int DEPTH         = 16,
    parameter int CLK_HZ        = 200_000_000,
    parameter int BAUD          = 9600,
    parameter int CHAR_CYCLES   = CLK_HZ / BAUD,
    parameter int TIMEOUT_CHARS = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_valid,
    input  logic [W-1:0]               rx_data,
    input  logic                       rx_enable,
    input  logic                       irq_enable,
    input  logic [1:0]                 trig_sel,
    input  logic                       fifo_clear,
    input  logic                       rd_pop,
    output logic [W-1:0]               rd_data,
    output logic [$clog2(DEPTH+1)-1:0] fill_count,
    output logic                       data_ready,
    output logic                       rx_irq
);
    localparam int CW    = $clog2(DEPTH+1);
    localparam int TICKS = TIMEOUT_CHARS * CHAR_CYCLES;

    logic [CW-1:0] count_next, thr;
    logic          push_ok, pop_ok, at_thr, fire;
    logic          set_evt, drop_evt, restart, cancel;

    assign thr    = CW'(trig_level(trig_sel));
    assign at_thr = (count_next >= thr);

    rxq_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (fifo_clear),
        .push_req   (rx_valid && rx_enable),
        .wdata      (rx_data),
        .pop_req    (rd_pop),
        .head_byte  (rd_data),
        .count      (fill_count),
        .count_next (count_next),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok)
    );

    assign restart  = push_ok && !at_thr;
    assign cancel   = fifo_clear || (push_ok && at_thr && irq_enable);
    assign set_evt  = (push_ok && at_thr) || fire;
    assign drop_evt = pop_ok && !at_thr;

    rxq_timeout #(.TICKS(TICKS)) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .cancel  (cancel),
        .fire    (fire)
    );

    rxq_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (fifo_clear),
        .set_evt    (set_evt),
        .drop_evt   (drop_evt),
        .irq_enable (irq_enable),
        .data_ready (data_ready),
        .rx_irq     (rx_irq)
    );

    p_no_store_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_enable && !rd_pop && !fifo_clear) |=> fill_count == $past(fill_count));

endmodule

// File: tb/tb_rxq_trigger_top.sv
`timescale 1ns/1ps
module tb_rxq_trigger_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_enable = 1'b1;
    logic       irq_enable = 1'b1;
    logic [1:0] trig_sel = 2'b10;
    logic       fifo_clear = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] fill_count;
    logic       data_ready, rx_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    event pop_ev;

    always #2.5 clk = ~clk;

    rxq_trigger_top #(.CHAR_CYCLES(4)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_enable(rx_enable), .irq_enable(irq_enable), .trig_sel(trig_sel),
        .fifo_clear(fifo_clear), .rd_pop(rd_pop), .rd_data(rd_data),
        .fill_count(fill_count), .data_ready(data_ready), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: offers a byte, records what must come out
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        if (rx_enable && exp_q.size() < 16) exp_q.push_back(b);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        rd_pop = 1'b1;
        #1 -> pop_ev;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic clear_fifo();
        @(negedge clk);
        fifo_clear = 1'b1;
        exp_q.delete();
        @(negedge clk);
        fifo_clear = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares every popped byte against the scoreboard (R4, R9)
    always @(pop_ev) begin
        if (exp_q.size() == 0) chk("R9 empty read", rd_data, 8'hFF);
        else                   chk("R4 order", rd_data, exp_q.pop_front());
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 count", fill_count, 0);
        chk("R1 ready", data_ready, 0);
        chk("R1 irq", rx_irq, 0);
        chk("R9 reset rd_data", rd_data, 8'hFF);

        // threshold 8 (code 2'b10)
        for (int i = 0; i < 7; i++) send(8'h10 + 8'(i));
        chk("R3 below thr", data_ready, 0);
        send(8'h17);
        chk("R3 ready", data_ready, 1);
        chk("R3 irq", rx_irq, 1);
        chk("R2 code2 count", fill_count, 8);
        pop();
        chk("R4 count dec", fill_count, 7);
        chk("R5 ready drop", data_ready, 0);
        chk("R5 irq drop", rx_irq, 0);
        for (int i = 0; i < 7; i++) pop();
        pop();
        chk("R9 empty count", fill_count, 0);

        // threshold 1
        trig_sel = 2'b00;
        send(8'h21);
        chk("R2 code0 ready", data_ready, 1);
        clear_fifo();
        chk("R11 count", fill_count, 0);
        chk("R11 ready", data_ready, 0);
        chk("R11 rd_data", rd_data, 8'hFF);

        // interrupts disabled, threshold 4
        irq_enable = 1'b0;
        trig_sel = 2'b01;
        for (int i = 0; i < 4; i++) send(8'h30 + 8'(i));
        chk("R7 ready", data_ready, 1);
        chk("R7 irq off", rx_irq, 0);
        irq_enable = 1'b1;
        idle(2);
        chk("R7 no late irq", rx_irq, 0);
        clear_fifo();

        // timeout at threshold 14
        trig_sel = 2'b11;
        send(8'hA0);
        idle(40);
        send(8'hA1);
        idle(59);
        chk("R6 restart", data_ready, 0);
        idle(1);
        chk("R6 expiry ready", data_ready, 1);
        chk("R6 expiry irq", rx_irq, 1);
        irq_enable = 1'b0;
        idle(1);
        chk("R7 irq mute", rx_irq, 0);
        chk("R7 ready kept", data_ready, 1);
        irq_enable = 1'b1;
        clear_fifo();

        // cancel at threshold 4
        trig_sel = 2'b01;
        for (int i = 0; i < 4; i++) send(8'h50 + 8'(i));
        chk("R12 ready", data_ready, 1);
        pop();
        chk("R5 below again", data_ready, 0);
        idle(80);
        chk("R12 no stale fire", data_ready, 0);
        for (int i = 0; i < 3; i++) pop();
        clear_fifo();

        // receiver disabled
        rx_enable = 1'b0;
        send(8'h61);
        send(8'h62);
        chk("R8 count", fill_count, 0);
        rx_enable = 1'b1;

        // overflow and wrap
        trig_sel = 2'b11;
        for (int i = 0; i < 17; i++) send(8'h40 + 8'(i));
        chk("R10 count", fill_count, 16);
        chk("R10 ready", data_ready, 1);
        for (int i = 0; i < 16; i++) pop();
        chk("R10 drained", fill_count, 0);
        pop();
        trig_sel = 2'b00;
        for (int i = 0; i < 3; i++) send(8'hC0 + 8'(i));
        for (int i = 0; i < 3; i++) pop();
        chk("R4 wrap empty", fill_count, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule